// File: doc/BRIEF.md
# Serial-Bus Converter Command and Reference Controller

This block is the slave-side control logic of a 12-bit sampling converter on a two-wire serial bus. The block samples SCL and SDA with the system clock and drives SDA open-drain. It recognises its own 7-bit address, which is a fixed prefix plus two strap pins. In a write transfer it latches one command byte. In a read transfer it returns the converter result as two bytes, with the master acknowledging or not-acknowledging each byte.

The block tracks whether the internal reference is on. A command can switch the reference off at once. Switching it on is only armed by the command and happens at the next bus boundary, meaning a STOP or a (repeated) START. A settled flag follows the reference once a programmable delay has elapsed. The block also drives a power-mode output: power-down, sampling or converting. This output is derived from the transfer in progress and from the latched power-down bit.

Top module: `adc_i2c_ctrl`

## Requirements
- R1: After reset, refOn and refSettled are 0, powerMode is 0 (power-down), selCode is 0 and sdaPullLow is 0.
- R2: The slave acknowledges an address byte, sent MSB first, equal to 1,0,0,1,0,strapAddr[1],strapAddr[0],R/W. Bit 0 of that byte is 1 for a read and 0 for a write.
- R3: If the address does not match, the slave neither acknowledges nor drives SDA. It latches no command and returns no data until the next START.
- R4: The command byte follows the write address. Its bits [7:4] appear on selCode. Bit 3 is the reference enable and bit 2 is the converter-stay-on bit. The slave acknowledges the command byte.
- R5: A command with bit 3 = 1 while the reference is off does not turn refOn on. refOn rises only after the next STOP or START condition.
- R6: A command with bit 3 = 1 while the reference is on keeps refOn at 1. A command with bit 3 = 0 clears refOn before the command's acknowledge completes.
- R7: refSettled rises exactly SETTLE_CYCLES clock cycles after refOn rises. It is never 1 while refOn is 0.
- R8: A read returns {4'b0000, D[11:8]} first and then D[7:0]. The value is captured from convData when the read address is acknowledged.
- R9: The second byte is sent only if the master acknowledges the first. After a not-acknowledge the slave keeps SDA released until the next START.
- R10: powerMode is 2 (converting) from a read-address acknowledge until the next boundary. It is 1 (sampling) from command reception until the next boundary. Otherwise it is 1 if the last command had bit 2 = 1, and 0 if not.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Sampled serial clock line |
| sdaIn | input | 1 | Sampled serial data line |
| strapAddr | input | 2 | Address strap pins (low two address bits) |
| convData | input | 12 | Conversion result from the converter |
| sdaPullLow | output | 1 | 1 pulls SDA low, 0 releases it |
| refOn | output | 1 | Internal reference enabled |
| refSettled | output | 1 | Reference settling delay elapsed |
| powerMode | output | 2 | 0 power-down, 1 sampling, 2 converting |
| selCode | output | 4 | Latched command bits [7:4] |

## Verification
The bench checks refOn immediately after the command's acknowledge and again after the STOP or repeated START. A design that enabled the reference when the byte arrived would fail the first check. The settling delay is counted cycle by cycle from the rise of refOn, so an off-by-one in the counter shows up as a wrong count. Reads use two different result values, a master not-acknowledge after the first byte, and a change of convData after the address acknowledge. These cases catch swapped nibbles, late capture, and a slave that keeps transmitting after a not-acknowledge. A foreign address followed by a command byte must leave the reference and selCode unchanged, which catches a controller that latches bytes it was never addressed for.

// File: rtl/adc_i2c_pkg.sv
package adc_i2c_pkg;

  // Strobes from the bus controller to the datapath
  typedef struct packed {
    logic boundary;  // STOP or START seen
    logic shiftIn;   // sample SDA into the receive register
    logic latchCmd;  // command byte complete
    logic loadHi;    // read address accepted: load upper result byte
    logic loadLo;    // master acked first byte: load lower result byte
    logic shiftTx;   // advance the transmit register
  } ctlStrobe_t;

  typedef enum logic [1:0] {
    MODE_PDN    = 2'd0,
    MODE_SAMPLE = 2'd1,
    MODE_CONV   = 2'd2
  } pwrMode_t;

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_ADDR_END, S_ADDR_ACK,
    S_CMD, S_CMD_END, S_CMD_ACK,
    S_TX, S_TX_ACK, S_IGNORE
  } busState_t;

endpackage

// File: rtl/adc_i2c_ctl.sv
module adc_i2c_ctl
  import adc_i2c_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic       addrMatch,
  input  logic       rwBit,
  input  logic       txMsb,
  output ctlStrobe_t strb,
  output logic       sdaBit,
  output logic       sdaPullLow
);

  logic [SYNC_STAGES-1:0] sclSh, sdaSh;
  logic sclS, sdaS, sclPrev, sdaPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSh   <= '1;
      sdaSh   <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSh   <= {sclSh[SYNC_STAGES-2:0], sclIn};
      sdaSh   <= {sdaSh[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  assign sclS   = sclSh[SYNC_STAGES-1];
  assign sdaS   = sdaSh[SYNC_STAGES-1];
  assign sdaBit = sdaS;

  logic sclRise, sclFall, startCond, stopCond;
  assign sclRise   = sclS & ~sclPrev;
  assign sclFall   = ~sclS & sclPrev;
  assign startCond = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopCond  = sclS & sclPrev & ~sdaPrev & sdaS;

  busState_t  st, stN;
  logic [2:0] bitCnt, bitCntN;
  logic       firstByte, firstByteN, masterAck, masterAckN;

  always_comb begin
    stN        = st;
    bitCntN    = bitCnt;
    firstByteN = firstByte;
    masterAckN = masterAck;
    strb       = '0;
    if (startCond) begin
      strb.boundary = 1'b1;
      stN           = S_ADDR;
      bitCntN       = '0;
    end else if (stopCond) begin
      strb.boundary = 1'b1;
      stN           = S_IDLE;
    end else begin
      case (st)
        S_ADDR, S_CMD:
          if (sclRise) begin
            strb.shiftIn = 1'b1;
            if (bitCnt == 3'd7) stN = (st == S_ADDR) ? S_ADDR_END : S_CMD_END;
            else                bitCntN = 3'(bitCnt + 3'd1);
          end
        S_ADDR_END:
          if (sclFall) stN = addrMatch ? S_ADDR_ACK : S_IGNORE;
        S_ADDR_ACK:
          if (sclFall) begin
            bitCntN = '0;
            if (rwBit) begin
              strb.loadHi = 1'b1;
              firstByteN  = 1'b1;
              stN         = S_TX;
            end else begin
              stN = S_CMD;
            end
          end
        S_CMD_END:
          if (sclFall) begin
            strb.latchCmd = 1'b1;
            stN           = S_CMD_ACK;
          end
        S_CMD_ACK:
          if (sclFall) stN = S_IGNORE;
        S_TX:
          if (sclFall) begin
            if (bitCnt == 3'd7) stN = S_TX_ACK;
            else begin
              strb.shiftTx = 1'b1;
              bitCntN      = 3'(bitCnt + 3'd1);
            end
          end
        S_TX_ACK: begin
          if (sclRise) masterAckN = ~sdaS;
          if (sclFall) begin
            if (firstByte && masterAck) begin
              strb.loadLo = 1'b1;
              firstByteN  = 1'b0;
              bitCntN     = '0;
              stN         = S_TX;
            end else begin
              stN = S_IGNORE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st        <= S_IDLE;
      bitCnt    <= '0;
      firstByte <= 1'b0;
      masterAck <= 1'b0;
    end else begin
      st        <= stN;
      bitCnt    <= bitCntN;
      firstByte <= firstByteN;
      masterAck <= masterAckN;
    end
  end

  assign sdaPullLow = (st == S_ADDR_ACK) || (st == S_CMD_ACK) ||
                      ((st == S_TX) && !txMsb);

endmodule

// File: rtl/adc_i2c_dp.sv
module adc_i2c_dp
  import adc_i2c_pkg::*;
#(
  parameter logic [4:0] ADDR_PREFIX   = 5'b10010,
  parameter int         DATA_W        = 12,
  parameter int         SETTLE_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strb,
  input  logic              sdaBit,
  input  logic [1:0]        strapAddr,
  input  logic [DATA_W-1:0] convData,
  output logic              addrMatch,
  output logic              rwBit,
  output logic              txMsb,
  output logic              refOn,
  output logic              refSettled,
  output logic [1:0]        powerMode,
  output logic [3:0]        selCode
);

  localparam int HI_W  = DATA_W - 8;
  localparam int PAD_W = 8 - HI_W;
  localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);

  logic [7:0] rxReg, txReg, loHold;
  logic [7:0] hiByte;
  logic       pd0Reg, refArm, settled, convBusy, cmdPend;
  logic [CNT_W-1:0] settleCnt;

  assign hiByte    = {{PAD_W{1'b0}}, convData[DATA_W-1:8]};
  assign addrMatch = (rxReg[7:1] == {ADDR_PREFIX, strapAddr});
  assign rwBit     = rxReg[0];
  assign txMsb     = txReg[7];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxReg   <= '0;
      txReg   <= '1;
      loHold  <= '0;
      selCode <= '0;
      pd0Reg  <= 1'b0;
    end else begin
      if (strb.shiftIn) rxReg <= {rxReg[6:0], sdaBit};
      if (strb.loadHi) begin
        txReg  <= hiByte;
        loHold <= convData[7:0];
      end else if (strb.loadLo) begin
        txReg <= loHold;
      end else if (strb.shiftTx) begin
        txReg <= {txReg[6:0], 1'b1};
      end
      if (strb.latchCmd) begin
        selCode <= rxReg[7:4];
        pd0Reg  <= rxReg[2];
      end
    end
  end

  // Reference on/off: off acts at once, on waits for a bus boundary
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refOn  <= 1'b0;
      refArm <= 1'b0;
    end else if (strb.latchCmd) begin
      if (rxReg[3]) begin
        if (!refOn) refArm <= 1'b1;
      end else begin
        refOn  <= 1'b0;
        refArm <= 1'b0;
      end
    end else if (strb.boundary && refArm) begin
      refOn  <= 1'b1;
      refArm <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      settleCnt <= '0;
      settled   <= 1'b0;
    end else if (!refOn) begin
      settleCnt <= '0;
      settled   <= 1'b0;
    end else if (!settled) begin
      settleCnt <= CNT_W'(settleCnt + 1'b1);
      if (settleCnt == CNT_W'(SETTLE_CYCLES - 1)) settled <= 1'b1;
    end
  end

  assign refSettled = settled & refOn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      convBusy <= 1'b0;
      cmdPend  <= 1'b0;
    end else if (strb.boundary) begin
      convBusy <= 1'b0;
      cmdPend  <= 1'b0;
    end else if (strb.loadHi) begin
      convBusy <= 1'b1;
      cmdPend  <= 1'b0;
    end else if (strb.latchCmd) begin
      cmdPend <= 1'b1;
    end
  end

  pwrMode_t modeSel;
  always_comb begin
    if (convBusy)                modeSel = MODE_CONV;
    else if (cmdPend || pd0Reg)  modeSel = MODE_SAMPLE;
    else                         modeSel = MODE_PDN;
  end
  assign powerMode = modeSel;

endmodule

// File: rtl/adc_i2c_ctrl.sv
module adc_i2c_ctrl
  import adc_i2c_pkg::*;
#(
  parameter logic [4:0] ADDR_PREFIX   = 5'b10010,
  parameter int         DATA_W        = 12,
  parameter int         SETTLE_CYCLES = 16,
  parameter int         SYNC_STAGES   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [1:0]        strapAddr,
  input  logic [DATA_W-1:0] convData,
  output logic              sdaPullLow,
  output logic              refOn,
  output logic              refSettled,
  output logic [1:0]        powerMode,
  output logic [3:0]        selCode
);

  ctlStrobe_t strb;
  logic sdaBit, addrMatch, rwBit, txMsb;

  adc_i2c_ctl #(.SYNC_STAGES(SYNC_STAGES)) u_ctl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .addrMatch(addrMatch), .rwBit(rwBit), .txMsb(txMsb),
    .strb(strb), .sdaBit(sdaBit), .sdaPullLow(sdaPullLow)
  );

  adc_i2c_dp #(
    .ADDR_PREFIX(ADDR_PREFIX), .DATA_W(DATA_W), .SETTLE_CYCLES(SETTLE_CYCLES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .sdaBit(sdaBit),
    .strapAddr(strapAddr), .convData(convData),
    .addrMatch(addrMatch), .rwBit(rwBit), .txMsb(txMsb),
    .refOn(refOn), .refSettled(refSettled),
    .powerMode(powerMode), .selCode(selCode)
  );

endmodule

// File: rtl/adc_i2c_chk.sv
module adc_i2c_chk #(
  parameter int SETTLE_CYCLES = 16
) (
  input logic       clk,
  input logic       rstN,
  input logic       boundary,
  input logic       latchCmd,
  input logic       refOn,
  input logic       refSettled,
  input logic [1:0] powerMode
);

  localparam int CW = $clog2(SETTLE_CYCLES + 2);
  localparam logic [CW-1:0] CMAX = CW'(SETTLE_CYCLES + 1);

  logic [CW-1:0] onCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           onCnt <= '0;
    else if (!refOn)     onCnt <= '0;
    else if (onCnt != CMAX) onCnt <= CW'(onCnt + 1'b1);
  end

  // R7
  settled_needs_ref_chk: assert property (@(posedge clk) disable iff (!rstN)
    refSettled |-> refOn);

  // R7
  settle_delay_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(refSettled) |-> (onCnt == CW'(SETTLE_CYCLES)));

  // R5
  ref_on_at_boundary_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(refOn) |-> $past(boundary));

  // R6
  ref_off_by_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(refOn) |-> $past(latchCmd));

  // R10
  mode_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    powerMode != 2'd3);

endmodule

bind adc_i2c_ctrl adc_i2c_chk #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_chk (
  .clk(clk), .rstN(rstN), .boundary(strb.boundary), .latchCmd(strb.latchCmd),
  .refOn(refOn), .refSettled(refSettled), .powerMode(powerMode)
);

// File: tb/sim_adc_i2c_ctrl.sv
`timescale 1ns/1ps
module sim_adc_i2c_ctrl;

  localparam int SETTLE = 16;
  localparam int Q      = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic [1:0]  strap = 2'b10;
  logic [11:0] conv  = 12'h000;
  logic sdaPullLow, refOn, refSettled, sdaLine;
  logic [1:0] powerMode;
  logic [3:0] selCode;

  int nChecks = 0;
  int nFails  = 0;

  always #4 clk = ~clk;

  assign sdaLine = sdaM & ~sdaPullLow;

  adc_i2c_ctrl #(.SETTLE_CYCLES(SETTLE)) u0 (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine),
    .strapAddr(strap), .convData(conv), .sdaPullLow(sdaPullLow),
    .refOn(refOn), .refSettled(refSettled), .powerMode(powerMode),
    .selCode(selCode)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; waitQ();
    sclM = 1'b1; waitQ();
    sdaM = 1'b0; waitQ();
    sclM = 1'b0; waitQ();
  endtask

  task automatic busStop();
    sdaM = 1'b0; waitQ();
    sclM = 1'b1; waitQ();
    sdaM = 1'b1;
  endtask

  task automatic sendBit(input logic b);
    sdaM = b;    waitQ();
    sclM = 1'b1; waitQ(); waitQ();
    sclM = 1'b0; waitQ();
  endtask

  task automatic recvBit(output logic b);
    sdaM = 1'b1; waitQ();
    sclM = 1'b1; waitQ();
    b = sdaLine; waitQ();
    sclM = 1'b0; waitQ();
  endtask

  task automatic writeByte(input logic [7:0] d, output logic acked);
    logic b;
    for (int i = 7; i >= 0; i--) sendBit(d[i]);
    recvBit(b);
    acked = ~b;
  endtask

  task automatic readByte(input logic giveAck, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) recvBit(d[i]);
    sendBit(~giveAck);
  endtask

  task automatic waitRefOn(output int waited);
    waited = 0;
    while (!refOn && waited < 40) begin
      @(negedge clk);
      waited++;
    end
  endtask

  // Scenario: state after reset
  task automatic tReset();
    chk("R1 refOn", int'(refOn), 0);
    chk("R1 refSettled", int'(refSettled), 0);
    chk("R1 powerMode", int'(powerMode), 0);
    chk("R1 selCode", int'(selCode), 0);
    chk("R1 sdaPullLow", int'(sdaPullLow), 0);
  endtask

  // Scenario: foreign address is ignored
  task automatic tForeign();
    logic a;
    logic [7:0] d;
    busStart();
    writeByte(8'h90, a);           // strap 00, ours is 10
    chk("R3 no ack on foreign write address", int'(a), 0);
    writeByte(8'hFC, a);
    chk("R3 command byte not acked", int'(a), 0);
    busStop(); waitQ();
    chk("R3 refOn untouched", int'(refOn), 0);
    chk("R3 selCode untouched", int'(selCode), 0);
    busStart();
    writeByte(8'h91, a);
    chk("R3 no ack on foreign read address", int'(a), 0);
    readByte(1'b1, d);
    chk("R3 no data driven", int'(d), 8'hFF);
    busStop(); waitQ();
  endtask

  // Scenario: turn-on deferred to STOP, then settling delay
  task automatic tArmStop();
    logic a;
    int w, n;
    busStart();
    writeByte(8'h94, a);
    chk("R2 write address acked", int'(a), 1);
    writeByte(8'h78, a);           // sel 0111, enable=1, stay-on=0
    chk("R4 command acked", int'(a), 1);
    chk("R4 selCode", int'(selCode), 4'h7);
    chk("R5 refOn still off before boundary", int'(refOn), 0);
    chk("R10 sampling while command pending", int'(powerMode), 1);
    busStop();
    waitRefOn(w);
    chk("R5 refOn after STOP", int'(refOn), 1);
    n = 0;
    while (!refSettled && n < 100) begin
      @(negedge clk);
      n++;
    end
    chk("R7 settle delay cycles", n, SETTLE);
    chk("R10 power-down after boundary with stay-on=0", int'(powerMode), 0);
  endtask

  // Scenario: enable while on keeps the reference on
  task automatic tKeepOn();
    logic a;
    busStart();
    writeByte(8'h94, a);
    writeByte(8'hAC, a);           // sel 1010, enable=1, stay-on=1
    chk("R6 refOn kept by enable=1", int'(refOn), 1);
    chk("R4 selCode second pattern", int'(selCode), 4'hA);
    busStop(); waitQ();
    chk("R6 refOn still on after STOP", int'(refOn), 1);
    chk("R7 still settled", int'(refSettled), 1);
    chk("R10 sampling with stay-on=1", int'(powerMode), 1);
  endtask

  // Scenario: two-byte reads
  task automatic tRead(input logic [11:0] val);
    logic a;
    logic [7:0] d;
    conv = val;
    busStart();
    writeByte(8'h95, a);
    chk("R2 read address acked", int'(a), 1);
    chk("R10 converting during read", int'(powerMode), 2);
    conv = ~val;                   // must not affect captured value
    readByte(1'b1, d);
    chk("R8 first byte", int'(d), int'({4'h0, val[11:8]}));
    readByte(1'b0, d);
    chk("R8 second byte", int'(d), int'(val[7:0]));
    chk("R9 released after final nack", int'(sdaPullLow), 0);
    busStop(); waitQ();
  endtask

  // Scenario: nack on first byte ends the transfer
  task automatic tNackEarly();
    logic a;
    logic [7:0] d;
    conv = 12'h5A3;
    busStart();
    writeByte(8'h95, a);
    readByte(1'b0, d);
    chk("R8 first byte before nack", int'(d), 8'h05);
    readByte(1'b0, d);
    chk("R9 no second byte after nack", int'(d), 8'hFF);
    busStop(); waitQ();
  endtask

  // Scenario: enable=0 turns the reference off at once
  task automatic tOff();
    logic a;
    busStart();
    writeByte(8'h94, a);
    writeByte(8'h20, a);           // enable=0
    chk("R6 refOn off before STOP", int'(refOn), 0);
    chk("R7 settled cleared with ref", int'(refSettled), 0);
    busStop(); waitQ();
    chk("R6 refOn stays off", int'(refOn), 0);
  endtask

  // Scenario: repeated START also completes turn-on
  task automatic tRepStart();
    logic a;
    logic [7:0] d;
    int w;
    conv = 12'h0C3;
    busStart();
    writeByte(8'h94, a);
    writeByte(8'h08, a);           // enable=1
    chk("R5 armed only", int'(refOn), 0);
    busStart();                    // repeated START
    waitRefOn(w);
    chk("R5 refOn after repeated START", int'(refOn), 1);
    writeByte(8'h95, a);
    readByte(1'b1, d);
    chk("R8 first byte after Sr", int'(d), 8'h00);
    readByte(1'b0, d);
    chk("R8 second byte after Sr", int'(d), 8'hC3);
    busStop(); waitQ();
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    tReset();
    tForeign();
    tArmStop();
    tKeepOn();
    tRead(12'hA5C);
    tRead(12'h3F1);
    tNackEarly();
    tOff();
    tRepStart();
    summary();
    $finish;
  end

endmodule